// File: doc/BRIEF.md
# Serial Audio Receive Word FIFO

This block buffers received audio words for a single channel of a serial audio receiver. The serial side presents one word, with a one-cycle strobe, for each slot that is not masked. Software, or a bus bridge, drains the buffer through a register-style read port. The read port is either byte-wide or halfword-wide, selected on each access. The current fill level is exported so that neighbouring watermark logic can raise data-ready requests.

Some reads are not valid: a read while the channel is disabled, or a read from an empty buffer. These reads are discarded and leave the pointers untouched. Clearing the channel enable flushes the buffer to empty. A word that arrives while the buffer is full, with no read in the same cycle, is lost. The stored words are kept, and a sticky overrun flag is raised. The flag stays set until software writes a one to clear it.

Top module: `rx_word_fifo`

## Requirements
- R1: After reset the fill count is 0, `fifo_empty` is 1, `fifo_full` is 0, `ovr_flag` is 0 and `rd_data` reads 0.
- R2: A strobed word while the channel is enabled and the buffer is not full raises the count by one on the next clock. Words are returned in arrival order.
- R3: A read with `rd_wide`=1 returns the whole 16-bit head entry on `rd_data` in the same cycle. It removes that entry at the clock edge.
- R4: A read with `rd_wide`=0 returns bits [7:0] of the head entry with bits [15:8] forced to 0. It still removes the whole entry.
- R5: A read of an empty buffer is ignored. The count stays 0, `rd_data` reads 0, and a word pushed afterwards is the next word read.
- R6: While `chan_en` is 0, reads and pushes are ignored and `rd_data` reads 0. Any clock edge with `chan_en` low empties the buffer.
- R7: A word arriving while the buffer holds 8 entries, with no valid read in the same cycle, is dropped. The stored words are unchanged and `ovr_flag` is 1 after that edge.
- R8: A word arriving while the buffer is full, together with a valid read in the same cycle, is stored. No overrun is flagged and the count stays 8.
- R9: A push and a valid read in the same cycle leave the count unchanged.
- R10: `ovr_flag` stays 1 until a cycle with `ovr_clr`=1 and no new overrun. If an overrun and a clear fall in the same cycle, the flag stays set.
- R11: The count never exceeds 8. `fifo_full` is 1 exactly at count 8, and `fifo_empty` is 1 exactly at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; low flushes and blocks access |
| word_valid | input | 1 | One-cycle strobe: a received unmasked word is present |
| word_data | input | 16 | Received word |
| rd_req | input | 1 | Read access to the data register this cycle |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| rd_data | output | 16 | Read data, zero when the read is not valid |
| ovr_clr | input | 1 | Write-1-to-clear strobe for the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| fill_count | output | 4 | Number of stored words, 0 to 8 |
| fifo_empty | output | 1 | Buffer holds no words |
| fifo_full | output | 1 | Buffer holds 8 words |

## Verification
The bench fills the buffer to exactly eight words and strobes one more word, with and without a read in the same cycle. A design that compares against the wrong limit would either store the extra word over the oldest entry or flag an overrun that a freeing read should prevent. Empty reads and reads on a disabled channel are followed by a push and a read. Any pointer that moved on an ignored read then shows up as wrong data. Byte reads are followed by halfword reads, which catches a design that advances only half an entry or leaves the upper byte set. The bench also puts an overrun and a clear in the same cycle, and a design that lets the clear win loses the overrun.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic {
      RD_BYTE = 1'b0,
      RD_HALF = 1'b1
   } rd_size_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_ptr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_ptr,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && (wr_ptr == AW'(i))) begin
            mem_q[i] <= wr_data;
         end
      end
   end

   assign rd_word = mem_q[rd_ptr];
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_en,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          wr_en,
   output logic          pop_ok,
   output logic          overrun_evt,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   // a valid read frees the head entry, so a full buffer may still accept
   assign pop_ok      = chan_en && pop_req && !empty;
   assign wr_en       = chan_en && push_req && (!full || pop_ok);
   assign overrun_evt = chan_en && push_req && full && !pop_ok;

   always_ff @(posedge clk) begin
      if (!rst_n || !chan_en) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_en)  wr_q <= wr_q + AW'(1);
         if (pop_ok) rd_q <= rd_q + AW'(1);
         case ({wr_en, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;
   assign count  = cnt_q;
endmodule

// File: rtl/rxf_readmux.sv
module rxf_readmux
   import rxf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] head_word,
   input  logic              rd_wide,
   input  logic              data_ok,
   output logic [DATA_W-1:0] rd_data
);
   rd_size_e          size;
   logic [DATA_W-1:0] narrow;

   assign size = rd_size_e'(rd_wide);

   if (DATA_W == BYTE_W) begin : g_same
      assign narrow = head_word;
   end else begin : g_zext
      assign narrow = {{(DATA_W - BYTE_W){1'b0}}, head_word[BYTE_W-1:0]};
   end

   always_comb begin
      if (!data_ok)               rd_data = '0;
      else if (size == RD_HALF)   rd_data = head_word;
      else                        rd_data = narrow;
   end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              word_valid,
   input  logic [DATA_W-1:0] word_data,
   input  logic              rd_req,
   input  logic              rd_wide,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ovr_clr,
   output logic              ovr_flag,
   output logic [CW-1:0]     fill_count,
   output logic              fifo_empty,
   output logic              fifo_full
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rx_word_fifo: DEPTH must be a power of two of at least 2");
   end
   if (BYTE_W < 1 || BYTE_W > DATA_W) begin : g_bad_byte
      $error("rx_word_fifo: BYTE_W must lie in 1..DATA_W");
   end

   logic          wr_en, pop_ok, overrun_evt;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [DATA_W-1:0] head_word;
   logic          ovr_q;

   rxf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk         (clk),
      .rst_n       (rst_n),
      .chan_en     (chan_en),
      .push_req    (word_valid),
      .pop_req     (rd_req),
      .wr_en       (wr_en),
      .pop_ok      (pop_ok),
      .overrun_evt (overrun_evt),
      .wr_ptr      (wr_ptr),
      .rd_ptr      (rd_ptr),
      .count       (fill_count),
      .empty       (fifo_empty),
      .full        (fifo_full)
   );

   rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_ptr  (wr_ptr),
      .wr_data (word_data),
      .rd_ptr  (rd_ptr),
      .rd_word (head_word)
   );

   rxf_readmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rmux (
      .head_word (head_word),
      .rd_wide   (rd_wide),
      .data_ok   (chan_en && !fifo_empty),
      .rd_data   (rd_data)
   );

   // sticky overrun: a new event outranks a same-cycle clear
   always_ff @(posedge clk) begin
      if (!rst_n)           ovr_q <= 1'b0;
      else if (overrun_evt) ovr_q <= 1'b1;
      else if (ovr_clr)     ovr_q <= 1'b0;
   end

   assign ovr_flag = ovr_q;
   // pop_ok is consumed inside the pointer block; kept as a named net for clarity
   logic unused_ok;
   assign unused_ok = pop_ok;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              word_valid,
   input logic              rd_req,
   input logic              rd_wide,
   input logic [DATA_W-1:0] rd_data,
   input logic              ovr_clr,
   input logic              ovr_flag,
   input logic [CW-1:0]     fill_count,
   input logic              fifo_empty,
   input logic              fifo_full
);
   p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(DEPTH));

   p_push_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && word_valid && !rd_req && !fifo_full
      |=> fill_count == $past(fill_count) + CW'(1));

   p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_wide |-> rd_data[DATA_W-1:BYTE_W] == '0);

   p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && fifo_empty && rd_req && !word_valid |=> fifo_empty);

   p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> fill_count == '0);

   p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && fifo_full && word_valid && !rd_req
      |=> fifo_full && ovr_flag);

   p_full_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && fifo_full && word_valid && rd_req
      |=> fifo_full && (ovr_flag == $past(ovr_flag) || !ovr_flag));

   p_pushpop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en && word_valid && rd_req && !fifo_empty
      |=> $stable(fill_count));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag && !ovr_clr |=> ovr_flag);
endmodule

bind rx_word_fifo rxf_checker #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chan_en    (chan_en),
   .word_valid (word_valid),
   .rd_req     (rd_req),
   .rd_wide    (rd_wide),
   .rd_data    (rd_data),
   .ovr_clr    (ovr_clr),
   .ovr_flag   (ovr_flag),
   .fill_count (fill_count),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/tb_rx_word_fifo.sv
module tb_rx_word_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        word_valid = 1'b0;
   logic [15:0] word_data = '0;
   logic        rd_req = 1'b0;
   logic        rd_wide = 1'b1;
   logic        ovr_clr = 1'b0;
   logic [15:0] rd_data;
   logic        ovr_flag;
   logic [3:0]  fill_count;
   logic        fifo_empty, fifo_full;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rx_word_fifo dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
      .word_valid(word_valid), .word_data(word_data),
      .rd_req(rd_req), .rd_wide(rd_wide), .rd_data(rd_data),
      .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .fill_count(fill_count),
      .fifo_empty(fifo_empty), .fifo_full(fifo_full)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [15:0] d);
      word_valid = 1'b1;
      word_data  = d;
      step();
      word_valid = 1'b0;
   endtask

   task automatic pop(input bit wide, input logic [15:0] exp, input string tag);
      rd_req  = 1'b1;
      rd_wide = wide;
      #1;
      chk(rd_data == exp, tag, rd_data, exp);
      step();
      rd_req  = 1'b0;
      rd_wide = 1'b1;
   endtask

   task automatic flush();
      chan_en = 1'b0;
      step();
      chan_en = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   task automatic t_reset();
      chk(fill_count == 0, "R1 count", fill_count, 0);
      chk(fifo_empty == 1, "R1 empty", fifo_empty, 1);
      chk(fifo_full == 0, "R1 full", fifo_full, 0);
      chk(ovr_flag == 0, "R1 ovr", ovr_flag, 0);
      chk(rd_data == 0, "R1 rd_data", rd_data, 0);
   endtask

   task automatic t_order();
      push(16'hA1B2); push(16'hC3D4); push(16'hE5F6);
      chk(fill_count == 3, "R2 count after 3 pushes", fill_count, 3);
      pop(1, 16'hA1B2, "R3 wide read 0");
      pop(1, 16'hC3D4, "R3 wide read 1");
      pop(1, 16'hE5F6, "R2 order read 2");
      chk(fill_count == 0, "R3 count after pops", fill_count, 0);
   endtask

   task automatic t_byte();
      push(16'h12AB);
      pop(0, 16'h00AB, "R4 byte read zext");
      chk(fill_count == 0, "R4 byte pops entry", fill_count, 0);
      push(16'h3456); push(16'h789A);
      pop(0, 16'h0056, "R4 byte read low");
      pop(1, 16'h789A, "R4 next entry whole");
   endtask

   task automatic t_empty();
      rd_req = 1'b1;
      #1;
      chk(rd_data == 0, "R5 empty rd_data", rd_data, 0);
      step(); step();
      rd_req = 1'b0;
      chk(fill_count == 0, "R5 count stays 0", fill_count, 0);
      chk(fifo_empty == 1, "R5 still empty", fifo_empty, 1);
      push(16'h1111);
      pop(1, 16'h1111, "R5 no underflow");
   endtask

   task automatic t_disable();
      push(16'h0A0A); push(16'h0B0B);
      chan_en = 1'b0;
      #1;
      chk(rd_data == 0, "R6 rd_data while disabled", rd_data, 0);
      step();
      chk(fill_count == 0, "R6 flush on disable", fill_count, 0);
      push(16'h5555);
      rd_req = 1'b1; step(); rd_req = 1'b0;
      chk(fill_count == 0, "R6 push ignored", fill_count, 0);
      chk(ovr_flag == 0, "R6 no overrun", ovr_flag, 0);
      chan_en = 1'b1;
      step();
      chk(fifo_empty == 1, "R6 empty on re-enable", fifo_empty, 1);
      push(16'h4242);
      pop(1, 16'h4242, "R6 after re-enable");
   endtask

   task automatic t_overrun();
      for (int i = 0; i < 8; i++) begin
         push(16'h0100 + 16'(i));
         if (i == 6) chk(fifo_full == 0, "R11 not full at 7", fifo_full, 0);
      end
      chk(fifo_full == 1, "R11 full at 8", fifo_full, 1);
      push(16'hDEAD);
      chk(fill_count == 8, "R7 count held", fill_count, 8);
      chk(ovr_flag == 1, "R7 overrun set", ovr_flag, 1);
      step();
      chk(ovr_flag == 1, "R10 sticky", ovr_flag, 1);
      for (int i = 0; i < 8; i++) pop(1, 16'h0100 + 16'(i), "R7 stored kept");
      chk(fifo_empty == 1, "R7 extra word dropped", fifo_empty, 1);
      chk(ovr_flag == 1, "R10 sticky after drain", ovr_flag, 1);
      ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
      chk(ovr_flag == 0, "R10 cleared", ovr_flag, 0);
   endtask

   task automatic t_full_read();
      for (int i = 0; i < 8; i++) push(16'h0200 + 16'(i));
      word_valid = 1'b1; word_data = 16'h02FF;
      pop(1, 16'h0200, "R8 read at full");
      word_valid = 1'b0;
      chk(fill_count == 8, "R8 count stays 8", fill_count, 8);
      chk(ovr_flag == 0, "R8 no overrun", ovr_flag, 0);
      for (int i = 1; i < 8; i++) pop(1, 16'h0200 + 16'(i), "R8 drain");
      pop(1, 16'h02FF, "R8 word stored");
   endtask

   task automatic t_pushpop();
      push(16'h003A);
      word_valid = 1'b1; word_data = 16'h003B;
      pop(1, 16'h003A, "R9 read with push");
      word_valid = 1'b0;
      chk(fill_count == 1, "R9 count unchanged", fill_count, 1);
      pop(1, 16'h003B, "R9 pushed word");
   endtask

   task automatic t_set_vs_clear();
      for (int i = 0; i < 8; i++) push(16'h0300 + 16'(i));
      ovr_clr = 1'b1;
      push(16'hBEEF);
      ovr_clr = 1'b0;
      chk(ovr_flag == 1, "R10 set wins over clear", ovr_flag, 1);
      flush();
      chk(ovr_flag == 1, "R10 flush keeps flag", ovr_flag, 1);
      ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
      chk(ovr_flag == 0, "R10 clear after", ovr_flag, 0);
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1;
      chan_en = 1'b1;
      step();
      t_reset();
      t_order();
      t_byte();
      t_empty();
      t_disable();
      t_overrun();
      t_full_read();
      t_pushpop();
      t_set_vs_clear();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
   end
endmodule